// File: doc/BRIEF.md
# Speculative Load Ordering Violation Detector

This block sits beside a load queue in an out-of-order core where loads may read memory before every older store has produced its address. Loads take a queue slot in program order at dispatch and receive a sequence number. When a load executes, the block records its address, and also whether its data came from a pending store and which store that was. Until it retires, the load counts as speculative.

When a store commits, it presents its address, its store identifier and a mark. The mark is the sequence number that the next load would have taken when the store was dispatched, so every load at or after the mark is younger than the store. The block compares the store against every executed younger load in one cycle. A load that matches, and whose value was not forwarded from that same store, read stale data. The block reports the oldest such load on a one-cycle replay pulse. At the same clock edge it discards that load and every younger one, so the allocation point falls back to the reported sequence number. Loads retire in order from the head.

Only the low address bits, which need no translation, are stored and compared. A mismatch in those bits proves independence. A match is treated as a conflict even when the upper bits differ, which gives a safe but sometimes needless replay.

Top module: `spec_load_violation_detector`

## Requirements
- R1: After reset the queue is empty: `alloc_seq` is 0, `lq_full` is 0 and `replay_valid` is 0.
- R2: Each accepted allocation takes the current `alloc_seq` and advances it by one, modulo 2·DEPTH. `lq_full` rises when DEPTH loads are live, and an allocation requested while the queue is full is ignored.
- R3: A committing store that matches no executed younger load produces no replay and leaves `alloc_seq` unchanged.
- R4: A committing store whose compared address bits equal those of an executed, non-forwarded younger load raises `replay_valid` for exactly one cycle after the commit cycle. `replay_seq` holds that load's sequence number.
- R5: A load flagged as forwarded, with a forwarding store identifier equal to `st_id`, is not a violation for that store. A load forwarded from a different store identifier is a violation.
- R6: Loads whose sequence number precedes `st_mark` (wrap-aware) are never reported.
- R7: When several younger loads match, the one closest to `st_mark` (the oldest) is reported.
- R8: Only address bits [MATCH_BITS-1:0] are compared. Addresses that differ in those bits never match. Addresses equal in those bits match even when the upper bits differ.
- R9: A replay removes the reported load and all younger loads: in the cycle `replay_valid` is high, `alloc_seq` equals `replay_seq`. An allocation requested in the commit cycle is dropped.
- R10: A load that executes in the same cycle as the commit of an older matching store is reported.
- R11: A retire frees the head entry. This clears `lq_full`, and sequence numbers keep advancing and wrap across repeated allocate and retire.
- R12: Allocated loads that have not yet executed are never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a queue slot for the next load in program order |
| alloc_seq | output | IDX_W+1 | Sequence number the next allocated load receives |
| lq_full | output | 1 | DEPTH loads are live |
| exec_valid | input | 1 | A live load has executed |
| exec_seq | input | IDX_W+1 | Sequence number of the executed load |
| exec_addr | input | ADDR_W | Address read by the load |
| exec_fwd | input | 1 | Load data was forwarded from a pending store |
| exec_fwd_id | input | SID_W | Identifier of the store that forwarded the data |
| st_valid | input | 1 | A store commits this cycle |
| st_addr | input | ADDR_W | Address of the committing store |
| st_mark | input | IDX_W+1 | First load sequence number younger than the store |
| st_id | input | SID_W | Identifier of the committing store |
| ret_valid | input | 1 | Retire the head load |
| replay_valid | output | 1 | One-cycle pulse: an ordering violation was found |
| replay_seq | output | IDX_W+1 | Sequence number of the oldest violating load |

## Verification
Two functions can meet in one cycle: a load writing its address, and the commit of an older store to the same address. Loads that execute alongside the commit are driven deliberately, and the bench expects a replay of that load on the next edge even though the queue had no address recorded for it. The bench also requests an allocation in the same cycle as a violating commit. Afterwards the allocation point must equal the reported sequence number, which shows the new load was dropped by the flush. The oldest-match priority is swept over every pattern of matching loads and every store mark on a full queue. The partial address compare is swept over all store addresses.

// File: rtl/spec_load_violation_detector.sv
module spec_load_violation_detector #(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 16,
  parameter int MATCH_BITS = 12,
  parameter int SID_W      = 4,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int SEQ_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic [SEQ_W-1:0]  alloc_seq,
  output logic              lq_full,
  input  logic              exec_valid,
  input  logic [SEQ_W-1:0]  exec_seq,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              exec_fwd,
  input  logic [SID_W-1:0]  exec_fwd_id,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SEQ_W-1:0]  st_mark,
  input  logic [SID_W-1:0]  st_id,
  input  logic              ret_valid,
  output logic              replay_valid,
  output logic [SEQ_W-1:0]  replay_seq
);

  logic [SEQ_W-1:0]      head_q, tail_q;
  logic                  done_q  [DEPTH];
  logic [MATCH_BITS-1:0] addr_q  [DEPTH];
  logic                  fwd_q   [DEPTH];
  logic [SID_W-1:0]      fid_q   [DEPTH];
  logic                  replay_q;
  logic [SEQ_W-1:0]      replay_seq_q;

  logic [SEQ_W-1:0] count, mark_off;
  logic             flush;
  logic [SEQ_W-1:0] victim;
  logic             alloc_fire, ret_fire;
  logic [IDX_W-1:0] exec_idx, tail_idx;

  assign count     = tail_q - head_q;
  assign mark_off  = st_mark - head_q;
  assign lq_full   = (count == SEQ_W'(DEPTH));
  assign alloc_seq = tail_q;
  assign exec_idx  = exec_seq[IDX_W-1:0];
  assign tail_idx  = tail_q[IDX_W-1:0];

  always_comb begin
    flush  = 1'b0;
    victim = tail_q;
    for (int k = 0; k < DEPTH; k++) begin
      logic [SEQ_W-1:0]      s;
      logic [IDX_W-1:0]      ix;
      logic                  byp, e_done, e_fwd, hit;
      logic [MATCH_BITS-1:0] e_addr;
      logic [SID_W-1:0]      e_fid;
      s      = head_q + SEQ_W'(k);
      ix     = s[IDX_W-1:0];
      byp    = exec_valid && (exec_seq == s);
      e_done = done_q[ix] | byp;
      e_addr = byp ? exec_addr[MATCH_BITS-1:0] : addr_q[ix];
      e_fwd  = byp ? exec_fwd : fwd_q[ix];
      e_fid  = byp ? exec_fwd_id : fid_q[ix];
      hit    = st_valid && (SEQ_W'(k) < count) && (SEQ_W'(k) >= mark_off) &&
               e_done && (e_addr == st_addr[MATCH_BITS-1:0]) &&
               !(e_fwd && (e_fid == st_id));
      if (hit && !flush) begin
        flush  = 1'b1;
        victim = s;
      end
    end
  end

  assign alloc_fire = alloc_valid && !lq_full && !flush;
  assign ret_fire   = ret_valid && (count != '0) && !(flush && (victim == head_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q       <= '0;
      tail_q       <= '0;
      replay_q     <= 1'b0;
      replay_seq_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        done_q[i] <= 1'b0;
        addr_q[i] <= '0;
        fwd_q[i]  <= 1'b0;
        fid_q[i]  <= '0;
      end
    end else begin
      if (exec_valid) begin
        done_q[exec_idx] <= 1'b1;
        addr_q[exec_idx] <= exec_addr[MATCH_BITS-1:0];
        fwd_q[exec_idx]  <= exec_fwd;
        fid_q[exec_idx]  <= exec_fwd_id;
      end
      if (alloc_fire) done_q[tail_idx] <= 1'b0;
      if (flush) tail_q <= victim;
      else if (alloc_fire) tail_q <= tail_q + 1'b1;
      if (ret_fire) head_q <= head_q + 1'b1;
      replay_q <= flush;
      if (flush) replay_seq_q <= victim;
    end
  end

  assign replay_valid = replay_q;
  assign replay_seq   = replay_seq_q;

  p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= SEQ_W'(DEPTH));

  p_no_alloc_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_full && !st_valid) |=> $stable(alloc_seq));

  p_flush_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> (alloc_seq == replay_seq));

  p_replay_younger_r6: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> (SEQ_W'(replay_seq - $past(st_mark)) < SEQ_W'(DEPTH)));

  p_mark_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (mark_off <= count));

  p_exec_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (SEQ_W'(exec_seq - head_q) < count));

  p_retire_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && count != '0) |-> done_q[head_q[IDX_W-1:0]]);

endmodule

// File: tb/tb_spec_load_violation_detector.sv
`timescale 1ns/1ps
module tb_spec_load_violation_detector;
  localparam int DEPTH = 4, ADDR_W = 8, MB = 4, SID_W = 2, SEQ_W = 3;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, exec_valid = 0, exec_fwd = 0, st_valid = 0, ret_valid = 0;
  logic [SEQ_W-1:0] exec_seq = 0, st_mark = 0, alloc_seq, replay_seq;
  logic [ADDR_W-1:0] exec_addr = 0, st_addr = 0;
  logic [SID_W-1:0] exec_fwd_id = 0, st_id = 0;
  logic lq_full, replay_valid;
  int checks = 0, errors = 0;

  spec_load_violation_detector #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .MATCH_BITS(MB), .SID_W(SID_W)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .lq_full(lq_full),
    .exec_valid(exec_valid), .exec_seq(exec_seq), .exec_addr(exec_addr), .exec_fwd(exec_fwd),
    .exec_fwd_id(exec_fwd_id), .st_valid(st_valid), .st_addr(st_addr), .st_mark(st_mark),
    .st_id(st_id), .ret_valid(ret_valid), .replay_valid(replay_valid), .replay_seq(replay_seq));

  always #5 clk = ~clk;

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    alloc_valid = 0; exec_valid = 0; st_valid = 0; ret_valid = 0; exec_fwd = 0;
    rst_n = 0; tick; tick; rst_n = 1;
  endtask

  task automatic alloc_n(input int n);
    alloc_valid = 1; repeat (n) tick; alloc_valid = 0;
  endtask

  task automatic exec_ld(input int s, input int a, input bit f, input int fid);
    exec_valid = 1; exec_seq = SEQ_W'(s); exec_addr = ADDR_W'(a); exec_fwd = f; exec_fwd_id = SID_W'(fid);
    tick; exec_valid = 0; exec_fwd = 0;
  endtask

  task automatic commit(input int a, input int m, input int id);
    st_valid = 1; st_addr = ADDR_W'(a); st_mark = SEQ_W'(m); st_id = SID_W'(id);
    tick; st_valid = 0;
  endtask

  initial begin
    #1ms;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_s, hs;
    bit exp_v;
    do_reset;
    // R1
    chk("R1 alloc_seq", alloc_seq, 0);
    chk("R1 lq_full", lq_full, 0);
    chk("R1 replay_valid", replay_valid, 0);

    // R2: allocation sequence and full
    for (int k = 0; k < DEPTH; k++) begin
      chk("R2 alloc_seq", alloc_seq, k);
      alloc_n(1);
    end
    chk("R2 full", lq_full, 1);
    alloc_n(1);
    chk("R2 ignored when full", alloc_seq, 4);

    // R11: retire frees, sequence wraps
    hs = 0;
    for (int r = 0; r < 12; r++) begin
      exec_ld(hs, 8'h11, 0, 0);
      ret_valid = 1; tick; ret_valid = 0;
      hs = (hs + 1) % 8;
      chk("R11 full cleared", lq_full, 0);
      alloc_n(1);
      chk("R11 alloc_seq wrap", alloc_seq, (hs + 4) % 8);
    end

    // R4 R6 R7 R9 R3: sweep of marks and matching patterns
    for (int m = 0; m <= DEPTH; m++) begin
      for (int mask = 0; mask < 16; mask++) begin
        do_reset; alloc_n(4);
        for (int k = 0; k < DEPTH; k++) exec_ld(k, ((mask >> k) & 1) ? 8'h35 : 8'h36, 0, 0);
        exp_v = 0; exp_s = 4;
        for (int k = m; k < DEPTH; k++)
          if (((mask >> k) & 1) && !exp_v) begin exp_v = 1; exp_s = k; end
        commit(8'h35, m, 0);
        chk("R7 replay_valid", replay_valid, exp_v);
        if (exp_v) chk("R7 oldest replay_seq", replay_seq, exp_s);
        chk("R9 alloc_seq after commit", alloc_seq, exp_s);
        tick;
        chk("R4 single pulse", replay_valid, 0);
      end
    end

    // R8: partial address compare over all store addresses
    for (int sa = 0; sa < 256; sa++) begin
      do_reset; alloc_n(1);
      exec_ld(0, 8'h5A, 0, 0);
      commit(sa, 0, 0);
      chk("R8 low-bit match", replay_valid, (sa & 15) == 10);
    end

    // R5: forwarding
    do_reset; alloc_n(2);
    exec_ld(0, 8'h42, 1, 2);
    commit(8'h42, 0, 2);
    chk("R5 forwarded same store", replay_valid, 0);
    commit(8'h42, 0, 1);
    chk("R5 forwarded other store", replay_valid, 1);
    chk("R5 replay_seq", replay_seq, 0);

    // R9: allocation in the commit cycle is dropped
    do_reset; alloc_n(2);
    exec_ld(0, 8'h21, 0, 0);
    exec_ld(1, 8'h22, 0, 0);
    alloc_valid = 1;
    commit(8'h22, 0, 0);
    alloc_valid = 0;
    chk("R9 replay_seq", replay_seq, 1);
    chk("R9 alloc dropped", alloc_seq, 1);
    alloc_n(1);
    chk("R9 alloc resumes", alloc_seq, 2);

    // R10: execute and commit in the same cycle
    do_reset; alloc_n(2);
    exec_valid = 1; exec_seq = 1; exec_addr = 8'h77; exec_fwd = 0;
    st_valid = 1; st_addr = 8'h77; st_mark = 0; st_id = 0;
    tick; exec_valid = 0; st_valid = 0;
    chk("R10 same-cycle replay", replay_valid, 1);
    chk("R10 replay_seq", replay_seq, 1);

    // R12: unexecuted loads ignored
    do_reset; alloc_n(2);
    exec_ld(1, 8'h0C, 0, 0);
    commit(8'h00, 0, 0);
    chk("R12 unexecuted ignored", replay_valid, 0);
    chk("R12 alloc_seq kept", alloc_seq, 2);

    // R3: no match leaves state alone
    commit(8'h0B, 0, 0);
    chk("R3 no replay", replay_valid, 0);
    chk("R3 alloc_seq kept", alloc_seq, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule